// File: doc/BRIEF.md
# USB PHY Control Register Bank

This block is the register file that sits inside a USB transceiver of the low-pin-count style and is reached from the link side over a simple synchronous register port: an 8-bit address, 8-bit write data, a write strobe, a read strobe and registered read data. It holds two identification words, six byte-wide control registers, a live interrupt status view, an edge-capturing interrupt latch and a line-state debug view. The contents of the function, interface and OTG control registers are driven out on ports so that the transceiver datapath can act on them.

Each control register is reached through three neighbouring addresses. The lowest address replaces the whole value. The next one ORs the data into the register. The third clears the bits that are set in the data. Status bits enter on a port. The two enable registers choose which rising and which falling edges of each status bit are captured in the latch. Reading the latch returns its contents and empties it.

Setting the reset bit in function control starts a fixed-length soft reset. For its whole length a busy output is raised and every register access is ignored. The bit then clears itself.

Top module: `usb_phy_regbank`

## Requirements
- R1: After synchronous reset, function control is 0x41, interface control, OTG control and scratch are 0x00, both interrupt-enable registers are 0x1F, the latch is empty, busy is low and read data is 0x00.
- R2: Reads of addresses 0x00, 0x01, 0x02 and 0x03 return VENDOR_ID[7:0], VENDOR_ID[15:8], PRODUCT_ID[7:0] and PRODUCT_ID[15:8] in that order. Writes to these addresses have no effect.
- R3: The control registers have these base addresses: function control 0x04, interface control 0x07, OTG control 0x0A, rising enable 0x0D, falling enable 0x10 and scratch 0x16. A write to a base address loads the register with the write data.
- R4: A write to base+1 ORs the write data into the register.
- R5: A write to base+2 clears every register bit whose write-data bit is 1. Reads of base, base+1 and base+2 all return the register value.
- R6: A read of 0x13 returns {3'b000, status_in} as sampled on the read edge. The status bits are: bit0 host disconnect, bit1 VBUS valid, bit2 session valid, bit3 session end, bit4 ID ground.
- R7: A read of 0x15 returns {6'b000000, line_state}.
- R8: A latch bit is set when its status bit rises and its bit in the rising enable (0x0D) is 1, or when its status bit falls and its bit in the falling enable (0x10) is 1. Edges whose enable bit is 0 are not captured.
- R9: A read of 0x14 returns the latch and then clears it. If an enabled edge arrives in the same cycle as that read, the new edge's bit is set after the read.
- R10: When function-control bit 5 (soft reset) becomes set, busy is high for exactly RESET_CYCLES clock cycles, and then bit 5 clears while the other bits are kept. While busy is high, writes change nothing, reads leave read data unchanged and do not clear the latch.
- R11: Reads of 0x19 through 0xFF (including 0x2F) return 0x00. Writes to those addresses and to 0x13, 0x14 and 0x15 have no effect.
- R12: Read data is registered. It changes on the clock edge that samples an accepted read strobe and holds its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| status_in | input | 5 | Live status bits, already synchronous to clk |
| line_state | input | 2 | Live line-state bits |
| busy | output | 1 | Soft reset in progress; accesses ignored |
| func_ctrl | output | 8 | Function control value |
| iface_ctrl | output | 8 | Interface control value |
| otg_ctrl | output | 8 | OTG control value |

## Verification
The assertions assume that status_in and line_state are already synchronous to clk. Any change on them is therefore treated as an edge at the next clock, with no filtering. They also assume that the link never raises the read and write strobes in the same cycle. The bench changes status bits and strobes only at falling clock edges and never asserts both strobes together. The one exception to its rule of not accessing during busy is the sequence that checks accesses are ignored while the soft reset runs.

// File: rtl/usb_phy_regbank_pkg.sv
package usb_phy_regbank_pkg;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int NCTRL = 6;
  localparam int NSTAT = 5;

  localparam int IDX_FUNC  = 0;
  localparam int IDX_IFACE = 1;
  localparam int IDX_OTG   = 2;
  localparam int IDX_ENR   = 3;
  localparam int IDX_ENF   = 4;
  localparam int IDX_SCR   = 5;

  localparam logic [AW-1:0] ADR_VID_LO = 8'h00;
  localparam logic [AW-1:0] ADR_VID_HI = 8'h01;
  localparam logic [AW-1:0] ADR_PID_LO = 8'h02;
  localparam logic [AW-1:0] ADR_PID_HI = 8'h03;
  localparam logic [AW-1:0] ADR_STAT   = 8'h13;
  localparam logic [AW-1:0] ADR_LATCH  = 8'h14;
  localparam logic [AW-1:0] ADR_DEBUG  = 8'h15;
  localparam logic [AW-1:0] ADR_FIRST_UNMAPPED = 8'h19;

  localparam int FC_RESET_BIT = 5;

  function automatic logic [AW-1:0] ctrl_base(input int idx);
    case (idx)
      IDX_FUNC:  return 8'h04;
      IDX_IFACE: return 8'h07;
      IDX_OTG:   return 8'h0A;
      IDX_ENR:   return 8'h0D;
      IDX_ENF:   return 8'h10;
      default:   return 8'h16;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctrl_rst(input int idx);
    case (idx)
      IDX_FUNC: return 8'h41;
      IDX_ENR:  return 8'h1F;
      IDX_ENF:  return 8'h1F;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/phy_alias_reg.sv
module phy_alias_reg #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= RST_VAL;
    else if (load_en) q <= wdata & ~hw_clr;
    else if (set_en)  q <= (q | wdata) & ~hw_clr;
    else if (clr_en)  q <= q & ~wdata & ~hw_clr;
    else              q <= q & ~hw_clr;
  end

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !load_en && hw_clr == '0) |=> (q == ($past(q) | $past(wdata))));

  // R5
  clear_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !load_en && !set_en) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/phy_irq_latch.sv
module phy_irq_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] en_rise,
  input  logic [N-1:0] en_fall,
  input  logic         rd_clr,
  output logic [N-1:0] latch
);
  logic [N-1:0] stat_q;
  logic [N-1:0] rise_hit;
  logic [N-1:0] fall_hit;

  assign rise_hit = status & ~stat_q & en_rise;
  assign fall_hit = ~status & stat_q & en_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= status;
      latch  <= '0;
    end else begin
      stat_q <= status;
      latch  <= (latch & ~{N{rd_clr}}) | rise_hit | fall_hit;
    end
  end

  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && status == stat_q) |=> (latch == '0));

  // R8
  rise_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & ~stat_q & en_rise) != '0) |=>
      ((latch & $past(status & ~stat_q & en_rise)) == $past(status & ~stat_q & en_rise)));

  // R8
  fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ((~status & stat_q & en_fall) != '0) |=>
      ((latch & $past(~status & stat_q & en_fall)) == $past(~status & stat_q & en_fall)));
endmodule

// File: rtl/phy_reset_timer.sv
module phy_reset_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!active || done) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/usb_phy_regbank.sv
module usb_phy_regbank #(
  parameter logic [15:0] VENDOR_ID    = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID   = 16'h0F96,
  parameter int          RESET_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic [4:0] status_in,
  input  logic [1:0] line_state,
  output logic       busy,
  output logic [7:0] func_ctrl,
  output logic [7:0] iface_ctrl,
  output logic [7:0] otg_ctrl
);
  import usb_phy_regbank_pkg::*;

  logic [DW-1:0]    ctrl_q [NCTRL];
  logic [NSTAT-1:0] latch_q;
  logic             wr_ok;
  logic             rd_ok;
  logic             rst_done;
  logic [DW-1:0]    rd_val;

  assign busy  = ctrl_q[IDX_FUNC][FC_RESET_BIT];
  assign wr_ok = reg_wr & ~busy;
  assign rd_ok = reg_rd & ~busy;

  for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
    localparam logic [AW-1:0] BASE = ctrl_base(i);
    logic [DW-1:0] hw_clr;
    if (i == IDX_FUNC) begin : g_fc
      assign hw_clr = {2'b00, rst_done, 5'b00000};
    end else begin : g_plain
      assign hw_clr = '0;
    end
    phy_alias_reg #(.W(DW), .RST_VAL(ctrl_rst(i))) u_reg (
      .clk     (clk),
      .rst     (rst),
      .load_en (wr_ok && reg_addr == BASE),
      .set_en  (wr_ok && reg_addr == 8'(BASE + 8'd1)),
      .clr_en  (wr_ok && reg_addr == 8'(BASE + 8'd2)),
      .wdata   (reg_wdata),
      .hw_clr  (hw_clr),
      .q       (ctrl_q[i])
    );
  end

  phy_reset_timer #(.CYCLES(RESET_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (busy),
    .done   (rst_done)
  );

  phy_irq_latch #(.N(NSTAT)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .status  (status_in),
    .en_rise (ctrl_q[IDX_ENR][NSTAT-1:0]),
    .en_fall (ctrl_q[IDX_ENF][NSTAT-1:0]),
    .rd_clr  (rd_ok && reg_addr == ADR_LATCH),
    .latch   (latch_q)
  );

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      ADR_VID_LO: rd_val = VENDOR_ID[7:0];
      ADR_VID_HI: rd_val = VENDOR_ID[15:8];
      ADR_PID_LO: rd_val = PRODUCT_ID[7:0];
      ADR_PID_HI: rd_val = PRODUCT_ID[15:8];
      ADR_STAT:   rd_val = {{(DW-NSTAT){1'b0}}, status_in};
      ADR_LATCH:  rd_val = {{(DW-NSTAT){1'b0}}, latch_q};
      ADR_DEBUG:  rd_val = {6'b000000, line_state};
      default:    rd_val = '0;
    endcase
    for (int i = 0; i < NCTRL; i++) begin
      if (reg_addr >= ctrl_base(i) && reg_addr <= 8'(ctrl_base(i) + 8'd2))
        rd_val = ctrl_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_rdata <= '0;
    else if (rd_ok) reg_rdata <= rd_val;
  end

  assign func_ctrl  = ctrl_q[IDX_FUNC];
  assign iface_ctrl = ctrl_q[IDX_IFACE];
  assign otg_ctrl   = ctrl_q[IDX_OTG];

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_rd) |=> $stable(reg_rdata));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !busy && reg_addr >= ADR_FIRST_UNMAPPED) |=> (reg_rdata == 8'h00));

  // R7
  debug_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !busy && reg_addr == ADR_DEBUG) |=> (reg_rdata == {6'b000000, $past(line_state)}));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd) |=> $stable(reg_rdata));
endmodule

// File: tb/usb_phy_regbank_bench.sv
module usb_phy_regbank_bench;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [15:0] PID = 16'h0F96;
  localparam int RCYC = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_rdata;
  logic [4:0] status_in;
  logic [1:0] line_state;
  logic       busy;
  logic [7:0] func_ctrl;
  logic [7:0] iface_ctrl;
  logic [7:0] otg_ctrl;

  usb_phy_regbank #(.VENDOR_ID(VID), .PRODUCT_ID(PID), .RESET_CYCLES(RCYC)) u_usb_phy_regbank (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .status_in(status_in), .line_state(line_state), .busy(busy),
    .func_ctrl(func_ctrl), .iface_ctrl(iface_ctrl), .otg_ctrl(otg_ctrl)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int busy_cnt = 0;

  logic [7:0] m [6];
  logic [7:0] bases [6];
  logic [4:0] mlatch;
  logic [4:0] status_v;

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      8'h00: v = VID[7:0];
      8'h01: v = VID[15:8];
      8'h02: v = PID[7:0];
      8'h03: v = PID[15:8];
      8'h13: v = {3'b000, status_v};
      8'h14: v = {3'b000, mlatch};
      8'h15: v = {6'b000000, line_state};
      default: v = 8'h00;
    endcase
    for (int i = 0; i < 6; i++)
      if (a >= bases[i] && a <= bases[i] + 8'd2) v = m[i];
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a < 8'h04) return "R2";
    if (a < 8'h13 || (a >= 8'h16 && a < 8'h19)) return "R3";
    if (a == 8'h13) return "R6";
    if (a == 8'h14) return "R9";
    if (a == 8'h15) return "R7";
    return "R11";
  endfunction

  function automatic bit is_ctrl(input logic [7:0] a);
    for (int i = 0; i < 6; i++)
      if (a >= bases[i] && a <= bases[i] + 8'd2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    bit was_busy;
    @(negedge clk);
    was_busy = busy;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (!was_busy)
      for (int i = 0; i < 6; i++) begin
        if (a == bases[i])         m[i] = d;
        if (a == bases[i] + 8'd1)  m[i] = m[i] | d;
        if (a == bases[i] + 8'd2)  m[i] = m[i] & ~d;
      end
  endtask

  task automatic do_rd_chk(input logic [7:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    e = exp_rd(a);
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata, e, req);
    if (a == 8'h14) mlatch = 5'h00;
  endtask

  task automatic set_status(input logic [4:0] s);
    @(negedge clk);
    mlatch = mlatch | (s & ~status_v & m[3][4:0]) | (~s & status_v & m[4][4:0]);
    status_in = s;
    status_v = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bases = '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h10, 8'h16};
    m     = '{8'h41, 8'h00, 8'h00, 8'h1F, 8'h1F, 8'h00};
    mlatch = 5'h00; status_v = 5'h00;
    rst = 1'b1; reg_addr = 8'h00; reg_wdata = 8'h00; reg_wr = 1'b0; reg_rd = 1'b0;
    status_in = 5'h00; line_state = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state at the ports
    chk(reg_rdata, 8'h00, "R1 rdata");
    chk({7'd0, busy}, 8'h00, "R1 busy");
    chk(func_ctrl, 8'h41, "R1 func_ctrl");
    chk(iface_ctrl, 8'h00, "R1 iface_ctrl");
    chk(otg_ctrl, 8'h00, "R1 otg_ctrl");
    do_rd_chk(8'h0D, "R1 rise enable");
    do_rd_chk(8'h10, "R1 fall enable");
    do_rd_chk(8'h16, "R1 scratch");
    do_rd_chk(8'h14, "R1 latch");

    // Full address sweep with live inputs: R2 R6 R7 R11 and R9 read-clear
    line_state = 2'b10;
    set_status(5'h0A);
    for (int a = 0; a < 256; a++) do_rd_chk(8'(a), tag_of(8'(a)));
    do_rd_chk(8'h14, "R9 cleared after read");

    // R12 read data holds with no read strobe
    do_rd_chk(8'h01, "R12 read");
    repeat (5) @(negedge clk);
    chk(reg_rdata, VID[15:8], "R12 hold");

    // Writes to non-control addresses are ignored: R2 R11
    for (int a = 0; a < 256; a++)
      if (!is_ctrl(8'(a))) do_wr(8'(a), 8'hFF);
    line_state = 2'b01;
    for (int a = 0; a < 256; a++) do_rd_chk(8'(a), tag_of(8'(a)));

    // Alias sweeps: R3 write, R4 set, R5 clear
    for (int i = 0; i < 6; i++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] msk;
        msk = (i == 0) ? 8'hDF : 8'hFF;
        do_wr(bases[i], 8'(d) & msk);
        do_rd_chk(bases[i], "R3 write alias");
        do_wr(bases[i] + 8'd1, 8'(d * 37 + 11) & msk);
        do_rd_chk(bases[i] + 8'd1, "R4 set alias");
        do_wr(bases[i] + 8'd2, 8'(d * 91 + 5));
        do_rd_chk(bases[i] + 8'd2, "R5 clear alias");
      end
      chk(func_ctrl, m[0], "R3 func_ctrl port");
      chk(iface_ctrl, m[1], "R3 iface_ctrl port");
      chk(otg_ctrl, m[2], "R3 otg_ctrl port");
    end

    // R8 edge capture under enable patterns
    foreach (bases[k]) begin end
    for (int er = 0; er < 4; er++) begin
      for (int ef = 0; ef < 4; ef++) begin
        logic [7:0] re, fe;
        re = (er == 0) ? 8'h00 : (er == 1) ? 8'h1F : (er == 2) ? 8'h15 : 8'h0A;
        fe = (ef == 0) ? 8'h00 : (ef == 1) ? 8'h1F : (ef == 2) ? 8'h0C : 8'h13;
        do_wr(8'h0D, re);
        do_wr(8'h10, fe);
        do_rd_chk(8'h14, "R9 clear before pattern");
        for (int k = 0; k < 8; k++) set_status(5'((k * 13 + er * 7 + ef * 3) ^ (k << 2)));
        do_rd_chk(8'h14, "R8 edge capture");
      end
    end

    // R9 edge arriving with the clearing read wins
    do_wr(8'h0D, 8'h1F);
    do_wr(8'h10, 8'h1F);
    set_status(status_v ^ 5'h11);
    begin
      logic [7:0] e;
      @(negedge clk);
      e = {3'b000, mlatch};
      reg_addr = 8'h14; reg_rd = 1'b1;
      status_in = status_v ^ 5'h04;
      status_v = status_in;
      @(negedge clk);
      reg_rd = 1'b0;
      chk(reg_rdata, e, "R9 read with edge");
      mlatch = 5'h04;
    end
    do_rd_chk(8'h14, "R9 new edge kept");

    // R10 soft reset: busy length, accesses ignored
    set_status(status_v ^ 5'h02);
    do_rd_chk(8'h16, "R10 scratch before");
    begin
      logic [7:0] prev;
      prev = reg_rdata;
      busy_cnt = 0;
      do_wr(8'h05, 8'h20);
      chk(func_ctrl, m[0], "R10 reset bit set");
      do_wr(8'h16, ~m[5]);
      @(negedge clk);
      reg_addr = 8'h14; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      chk(reg_rdata, prev, "R10 read ignored while busy");
      repeat (12) @(negedge clk);
      chk(8'(busy_cnt), 8'(RCYC), "R10 busy length");
      m[0] = m[0] & 8'hDF;
      chk(func_ctrl, m[0], "R10 reset bit self-clear");
      chk({7'd0, busy}, 8'h00, "R10 busy released");
    end
    do_rd_chk(8'h16, "R10 write ignored while busy");
    do_rd_chk(8'h14, "R10 latch kept while busy");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule